// File: doc/BRIEF.md
# Strided Vector Load Controller over Interleaved Banks

This block streams the elements of one vector load out of a set of interleaved memory banks. A start pulse captures a base word address, a constant stride and an element count. The controller then issues one element per cycle at address base plus index times stride. Each element goes to the bank named by the low address bits. The block delivers the loaded words, tagged with their element index, in index order and after a fixed latency. A single-cycle done pulse marks the end of the vector.

Every bank has a busy window after each access. An element whose bank is still inside that window is held and retried on the following cycles; it is never skipped. Strides that keep landing on a few banks therefore slow the stream. Because every accepted element takes the same latency, results still leave in order, with no reorder storage. The bank contents are internal registers loaded with a fixed pattern at reset, which lets a load be checked against its address.

Top module: `vec_bank_ctrl`

## Requirements
- R1: Element i reads word address a = (base + i*stride) mod 256, from bank a mod 16 at row a/16. The word at address a holds a zero-extended in bits 31:0 and (a zero-extended) XOR 32'h5A5A5A5A in bits 63:32.
- R2: While the target banks are free, one element is accepted per cycle. A unit-stride 64-element vector gives its done pulse 77 cycles after the start cycle.
- R3: A bank accepts no access within 4 cycles of the start of its previous access. An access exactly 4 cycles later is accepted. A stride that is a multiple of 16, or 0, therefore yields one element per 4 cycles.
- R4: A stalled element is retried until it is accepted. The indices delivered are 0 up to vlen-1 with none missing.
- R5: Data for an element appears on the output 12 cycles after the cycle in which it was accepted. With free banks, element 0 appears 13 cycles after the start cycle.
- R6: Each output word carries its element index, and indices leave in strictly increasing order.
- R7: done_o is high for exactly one cycle, in the cycle after the last element is delivered.
- R8: A vlen above 64 is treated as 64. A vlen of 0 delivers no data and raises done_o in the cycle after the start cycle.
- R9: start_i is ignored while a vector is issuing or its data is still in flight.
- R10: While reset is asserted, and after its release, rd_valid_o and done_o stay low until a new start. A reset in the middle of a vector cancels it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a vector load with the values on the next three inputs |
| base_i | input | 8 | Base word address |
| stride_i | input | 8 | Stride in words, taken modulo 256 |
| vlen_i | input | 7 | Element count, 0 to 64; larger values are treated as 64 |
| rd_valid_o | output | 1 | An element is on rd_idx_o and rd_data_o |
| rd_idx_o | output | 6 | Element index of the output word |
| rd_data_o | output | 64 | Loaded word |
| done_o | output | 1 | One-cycle pulse after the last element |

## Verification
Two events can fall in the same cycle: a bank's busy window expiring, and the held element that targets that bank being retried. Strides of 4, 8, 16, 0 and 48 make the stream come back to a bank exactly at, or before, the end of its window. Each of these vectors is judged by the cycle offset of its done pulse, which is computed from the 4-cycle rule, and by the order and content of every delivered word. A second collision, between a new start and a vector that is still issuing or draining, is provoked at both points and judged by the absence of any extra output.

// File: rtl/vbc_pkg.sv
`timescale 1ns/1ps
package vbc_pkg;
  localparam int DEF_NB    = 16;
  localparam int DEF_ROWS  = 16;
  localparam int DEF_DW    = 64;
  localparam int DEF_MAXVL = 64;
  localparam int DEF_BUSY  = 4;
  localparam int DEF_LAT   = 12;

  // reset content of a word, keyed by its word address
  function automatic logic [63:0] init_word(int unsigned addr);
    logic [31:0] a;
    a = addr;
    return {a ^ 32'h5A5A_5A5A, a};
  endfunction
endpackage

// File: rtl/vbc_issue.sv
`timescale 1ns/1ps
module vbc_issue #(
  parameter int AW    = 8,
  parameter int IDXW  = 6,
  parameter int VLW   = 7,
  parameter int MAXVL = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [AW-1:0]   base_i,
  input  logic [AW-1:0]   stride_i,
  input  logic [VLW-1:0]  vlen_i,
  input  logic            drained_i,
  input  logic            grant_i,
  output logic            fire_o,
  output logic [AW-1:0]   addr_o,
  output logic [IDXW-1:0] idx_o,
  output logic [IDXW-1:0] last_idx_o,
  output logic            zero_done_o
);
  logic            act_q;
  logic [AW-1:0]   addr_q, stride_q;
  logic [IDXW-1:0] idx_q, last_q;
  logic [VLW-1:0]  vlen_eff, vlen_m1;
  logic            take;

  assign vlen_eff    = (vlen_i > VLW'(MAXVL)) ? VLW'(MAXVL) : vlen_i;
  assign vlen_m1     = vlen_eff - VLW'(1);
  assign take        = start_i && !act_q && drained_i;
  assign fire_o      = act_q && grant_i;
  assign zero_done_o = take && (vlen_eff == '0);
  assign addr_o      = addr_q;
  assign idx_o       = idx_q;
  assign last_idx_o  = last_q;

  // address advances by stride on each accept; no multiplier
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q    <= 1'b0;
      addr_q   <= '0;
      stride_q <= '0;
      idx_q    <= '0;
      last_q   <= '0;
    end else if (take) begin
      act_q    <= (vlen_eff != '0);
      addr_q   <= base_i;
      stride_q <= stride_i;
      idx_q    <= '0;
      last_q   <= vlen_m1[IDXW-1:0];
    end else if (fire_o) begin
      addr_q <= addr_q + stride_q;
      idx_q  <= idx_q + IDXW'(1);
      if (idx_q == last_q) act_q <= 1'b0;
    end
  end
endmodule

// File: rtl/vbc_bank_busy.sv
`timescale 1ns/1ps
module vbc_bank_busy #(
  parameter int NB   = 16,
  parameter int BW   = 4,
  parameter int BUSY = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  input  logic [BW-1:0] bank_i,
  output logic          free_o
);
  localparam int TW = (BUSY > 1) ? $clog2(BUSY) : 1;

  logic [NB-1:0] free;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [TW-1:0] tmr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            tmr_q <= '0;
      else if (fire_i && bank_i == BW'(b))    tmr_q <= TW'(BUSY - 1);
      else if (tmr_q != '0)                   tmr_q <= tmr_q - TW'(1);
    end
    assign free[b] = (tmr_q == '0);
  end

  assign free_o = free[bank_i];
endmodule

// File: rtl/vbc_bank_array.sv
`timescale 1ns/1ps
module vbc_bank_array #(
  parameter int NB   = 16,
  parameter int BW   = 4,
  parameter int ROWS = 16,
  parameter int RW   = 4,
  parameter int DW   = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [BW-1:0] bank_i,
  input  logic [RW-1:0] row_i,
  output logic [DW-1:0] data_o
);
  logic [DW-1:0] bank_rd [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [DW-1:0] row_q [ROWS];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int r = 0; r < ROWS; r++)
          row_q[r] <= DW'(vbc_pkg::init_word(r * NB + b));
      end
    end
    assign bank_rd[b] = row_q[row_i];
  end

  assign data_o = bank_rd[bank_i];
endmodule

// File: rtl/vbc_ret_pipe.sv
`timescale 1ns/1ps
module vbc_ret_pipe #(
  parameter int LAT  = 12,
  parameter int IDXW = 6,
  parameter int DW   = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fire_i,
  input  logic [IDXW-1:0] idx_i,
  input  logic [DW-1:0]   data_i,
  input  logic [IDXW-1:0] last_idx_i,
  input  logic            zero_done_i,
  output logic            vld_o,
  output logic [IDXW-1:0] idx_o,
  output logic [DW-1:0]   data_o,
  output logic            done_o,
  output logic            empty_o
);
  logic [LAT-1:0]  vld_q;
  logic [IDXW-1:0] idx_q  [LAT];
  logic [DW-1:0]   data_q [LAT];
  logic            done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      done_q <= 1'b0;
    end else begin
      vld_q  <= {vld_q[LAT-2:0], fire_i};
      done_q <= zero_done_i || (vld_q[LAT-1] && idx_q[LAT-1] == last_idx_i);
    end
  end

  // payload needs no reset; qualified by vld_q
  always_ff @(posedge clk_i) begin
    idx_q[0]  <= idx_i;
    data_q[0] <= data_i;
    for (int k = 1; k < LAT; k++) begin
      idx_q[k]  <= idx_q[k-1];
      data_q[k] <= data_q[k-1];
    end
  end

  assign vld_o   = vld_q[LAT-1];
  assign idx_o   = idx_q[LAT-1];
  assign data_o  = data_q[LAT-1];
  assign done_o  = done_q;
  assign empty_o = (vld_q == '0);
endmodule

// File: rtl/vec_bank_ctrl.sv
`timescale 1ns/1ps
module vec_bank_ctrl #(
  parameter int NB    = vbc_pkg::DEF_NB,
  parameter int ROWS  = vbc_pkg::DEF_ROWS,
  parameter int DW    = vbc_pkg::DEF_DW,
  parameter int MAXVL = vbc_pkg::DEF_MAXVL,
  parameter int BUSY  = vbc_pkg::DEF_BUSY,
  parameter int LAT   = vbc_pkg::DEF_LAT,
  localparam int BW   = $clog2(NB),
  localparam int RW   = $clog2(ROWS),
  localparam int AW   = BW + RW,
  localparam int IDXW = $clog2(MAXVL),
  localparam int VLW  = IDXW + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [AW-1:0]   base_i,
  input  logic [AW-1:0]   stride_i,
  input  logic [VLW-1:0]  vlen_i,
  output logic            rd_valid_o,
  output logic [IDXW-1:0] rd_idx_o,
  output logic [DW-1:0]   rd_data_o,
  output logic            done_o
);
  logic            fire, grant, drained, zero_done;
  logic [AW-1:0]   addr;
  logic [BW-1:0]   bank;
  logic [RW-1:0]   row;
  logic [IDXW-1:0] idx, last_idx;
  logic [DW-1:0]   rd_word;

  assign bank = addr[BW-1:0];
  assign row  = addr[AW-1:BW];

  vbc_issue #(.AW(AW), .IDXW(IDXW), .VLW(VLW), .MAXVL(MAXVL)) u_issue (
    .clk_i, .rst_ni, .start_i, .base_i, .stride_i, .vlen_i,
    .drained_i(drained), .grant_i(grant), .fire_o(fire), .addr_o(addr),
    .idx_o(idx), .last_idx_o(last_idx), .zero_done_o(zero_done)
  );

  vbc_bank_busy #(.NB(NB), .BW(BW), .BUSY(BUSY)) u_busy (
    .clk_i, .rst_ni, .fire_i(fire), .bank_i(bank), .free_o(grant)
  );

  vbc_bank_array #(.NB(NB), .BW(BW), .ROWS(ROWS), .RW(RW), .DW(DW)) u_banks (
    .clk_i, .rst_ni, .bank_i(bank), .row_i(row), .data_o(rd_word)
  );

  vbc_ret_pipe #(.LAT(LAT), .IDXW(IDXW), .DW(DW)) u_ret (
    .clk_i, .rst_ni, .fire_i(fire), .idx_i(idx), .data_i(rd_word),
    .last_idx_i(last_idx), .zero_done_i(zero_done),
    .vld_o(rd_valid_o), .idx_o(rd_idx_o), .data_o(rd_data_o),
    .done_o(done_o), .empty_o(drained)
  );
endmodule

// File: rtl/vec_bank_ctrl_chk.sv
`timescale 1ns/1ps
module vec_bank_ctrl_chk #(
  parameter int NB   = 16,
  parameter int BUSY = 4,
  parameter int LAT  = 12,
  parameter int IDXW = 6,
  localparam int BW  = $clog2(NB),
  localparam int SW  = $clog2(BUSY + 1)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            fire_i,
  input logic [BW-1:0]   bank_i,
  input logic            rd_valid_i,
  input logic [IDXW-1:0] rd_idx_i,
  input logic [IDXW-1:0] last_idx_i,
  input logic            done_i
);
  logic [SW-1:0]   since_q [NB];
  logic [LAT-1:0]  fire_sr_q;
  logic            seen_q;
  logic [IDXW-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < NB; b++) since_q[b] <= SW'(BUSY);
      fire_sr_q <= '0;
      seen_q    <= 1'b0;
      prev_q    <= '0;
    end else begin
      for (int b = 0; b < NB; b++) begin
        if (fire_i && bank_i == BW'(b))      since_q[b] <= SW'(1);
        else if (since_q[b] < SW'(BUSY))     since_q[b] <= since_q[b] + SW'(1);
      end
      fire_sr_q <= {fire_sr_q[LAT-2:0], fire_i};
      if (done_i) seen_q <= 1'b0;
      else if (rd_valid_i) begin
        seen_q <= 1'b1;
        prev_q <= rd_idx_i;
      end
    end
  end

  AST_BANK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |-> since_q[bank_i] >= SW'(BUSY)); // R3
  AST_FIXED_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i == fire_sr_q[LAT-1]); // R5
  AST_IDX_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && !seen_q) |-> rd_idx_i == '0); // R4
  AST_IDX_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && seen_q) |-> rd_idx_i == prev_q + IDXW'(1)); // R6
  AST_DONE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i); // R7
  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && rd_idx_i == last_idx_i) |=> done_i); // R7
endmodule

bind vec_bank_ctrl vec_bank_ctrl_chk #(.NB(NB), .BUSY(BUSY), .LAT(LAT), .IDXW(IDXW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(fire), .bank_i(bank),
  .rd_valid_i(rd_valid_o), .rd_idx_i(rd_idx_o), .last_idx_i(last_idx),
  .done_i(done_o)
);

// File: tb/vec_bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module vec_bank_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  base = '0, stride = '0;
  logic [6:0]  vlen = '0;
  logic        rd_valid, done;
  logic [5:0]  rd_idx;
  logic [63:0] rd_data;
  int          cyc = 0;
  int          n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vec_bank_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_i(base),
    .stride_i(stride), .vlen_i(vlen), .rd_valid_o(rd_valid),
    .rd_idx_o(rd_idx), .rd_data_o(rd_data), .done_o(done)
  );

  // columns: base, stride, vlen, done offset, elements
  localparam int NV = 10;
  localparam int V_B [NV] = '{0,   0,  0,  5, 0, 7, 250, 3,  9, 0};
  localparam int V_S [NV] = '{1,  16,  8,  3, 4, 0,   1, 2, 48, 255};
  localparam int V_L [NV] = '{8,   4,  6, 64,10, 3, 100,20,  5, 16};
  localparam int V_D [NV] = '{21, 26, 23, 77,23,22,  77,33, 30, 29};
  localparam int V_N [NV] = '{8,   4,  6, 64,10, 3,  64,20,  5, 16};

  function automatic logic [63:0] exp_word(int a);
    logic [63:0] w;
    w[31:0]  = 32'(a & 255);
    w[63:32] = w[31:0] ^ 32'h5A5A_5A5A;
    return w;
  endfunction

  task automatic check(bit ok, string rq, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // inj >= 0: pulse a second start at that loop step (must be ignored)
  task automatic run_vec(int b, int st, int vl, int exp_d, int exp_n,
                         int inj, string rq);
    int s, n, d, extra;
    bit bad;
    logic [63:0] bad_act, bad_exp;
    n = 0; d = -1; bad = 1'b0; extra = 0;
    bad_act = '0; bad_exp = '0;
    @(negedge clk);
    start = 1'b1; base = 8'(b); stride = 8'(st); vlen = 7'(vl); s = cyc;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 400; k++) begin
      if (k == inj) begin
        start = 1'b1; base = 8'd100; stride = 8'd1; vlen = 7'd2;
      end else start = 1'b0;
      if (rd_valid) begin
        if (!bad && (rd_idx != 6'(n) || rd_data != exp_word(b + n * st))) begin
          bad = 1'b1;
          bad_act = rd_data;
          bad_exp = exp_word(b + n * st);
        end
        n++;
      end
      if (done) begin
        d = cyc - s;
        break;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(!bad, rq, "R1 R6 element word/index", bad_act, bad_exp);
    check(n == exp_n, rq, "R4 element count", n, exp_n);
    check(d == exp_d, rq, "R3 R5 R7 done offset", d, exp_d);
    if (inj >= 0) begin
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (rd_valid || done) extra++;
      end
      check(extra == 0, "R9", "outputs after ignored start", extra, 0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check(!rd_valid && !done, "R10", "outputs in reset", {rd_valid, done}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!rd_valid && !done, "R10", "outputs after reset", {rd_valid, done}, 0);

    // table walk: R1 R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++)
      run_vec(V_B[i], V_S[i], V_L[i], V_D[i], V_N[i], -1, $sformatf("vec%0d", i));

    // R8: zero length
    run_vec(20, 1, 0, 1, 0, -1, "R8 zero length");

    // R9: start while issuing, then start while draining
    run_vec(0, 1, 8, 21, 8, 3, "R9 start while issuing");
    run_vec(0, 1, 8, 21, 8, 12, "R9 start while draining");

    // R10: reset mid-vector cancels it
    begin
      int seen;
      seen = 0;
      @(negedge clk);
      start = 1'b1; base = 8'd0; stride = 8'd1; vlen = 7'd16;
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        if (rd_valid || done) seen++;
      end
      check(seen == 0, "R10", "outputs after mid-vector reset", seen, 0);
    end
    run_vec(32, 1, 4, 17, 4, -1, "R10 restart after reset");

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule